// File: doc/BRIEF.md
# Four-Channel DMA Request Service Engine

This block serves block-transfer requests from up to four peripherals. Each peripheral raises a request line. The engine picks one channel whose request is high and whose mask bit is clear, and then moves a whole block of bytes. Each byte crosses a simple byte-wide bus in two handshakes: one read from the source and one write to the destination. The peripheral side always uses that channel's fixed data address. The memory side uses an address built from a global memory base, the channel's base address, a running offset and a 7-bit page field.

When the block has moved, the channel masks itself, sets its status bit and sends the peripheral a one-cycle "handled" pulse, so the peripheral can drop its request. The engine then goes back to idle and scans again.

Each channel has a 32-bit page register. The host writes it one byte at a time through a small write port. The mode byte, the mask vector, and each channel's base and count are supplied from outside. The engine samples them when a channel is granted.

The controller has four states:
- `ST_IDLE`: waits for a qualified request.
- `ST_SRC`: reads one byte from the source.
- `ST_DST`: writes that byte to the destination.
- `ST_DONE`: the one completion cycle.

It has six transitions:
- grant: `ST_IDLE` to `ST_SRC`, for a write or read mode.
- grant-verify: `ST_IDLE` to `ST_DONE`, for verify or an unused mode.
- fetched: `ST_SRC` to `ST_DST`, on acknowledge.
- next-byte: `ST_DST` to `ST_SRC`, on acknowledge when bytes remain.
- last-byte: `ST_DST` to `ST_DONE`, on acknowledge of the final byte.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the mask vector is all ones, the status vector, every page register and every current-address value are zero, and busy, bus request and all handled lines are low.
- R2: Page register bytes are written through `page_off_i`. Offset 0 holds bits 31:24, offset 1 holds bits 23:16, offset 2 holds bits 15:8 and offset 3 holds bits 7:0. Writes with offsets 4 to 7 change nothing.
- R3: A memory-side address equals `MEM_BASE` plus the channel base plus the byte offset. Page register bits 6:0 are OR'ed into that sum at bit 16. Page bit 7 (a direction flag) and page bits 31:8 never reach the address.
- R4: The transfer kind is `mode_i[5:2]`, sampled at grant. 1 means write (peripheral to memory), 2 means read (memory to peripheral), and 0 or any other value means verify. The other mode bits have no effect.
- R5: A granted write or read moves count+1 bytes. The offset starts at 0 and rises by one per byte.
- R6: The bus request stays high, with address, direction and write data stable, until the acknowledge. Each write carries the byte returned by the preceding read of the same transfer. Read phases have `bus_we_o` at 0 and write phases have it at 1.
- R7: When the memory-side access of a byte is acknowledged, that channel's current address becomes base plus that byte's offset. A verify grant leaves the current address unchanged.
- R8: A channel is granted only when its request is high and its mask bit is 0. Among qualified channels the lowest index wins. A fresh scan follows every completion.
- R9: At completion the channel's handled line pulses for exactly one cycle, and from the next cycle its mask bit and status bit are set.
- R10: A verify grant, or a grant with an unused mode value, makes no bus access and still completes as in R9.
- R11: Busy is high from the cycle after the grant through the completion cycle. It is high whenever the bus request or a handled line is high.
- R12: `mask_ld_i` loads the whole mask vector and `status_clr_i` zeroes the status vector. A completion in the same cycle still sets its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drq_i | input | NCH | Per-channel transfer request |
| handled_o | output | NCH | One-cycle completion pulse per channel |
| mode_i | input | 8 | Mode byte; bits 5:2 select the transfer kind |
| mask_ld_i | input | 1 | Load the mask vector |
| mask_val_i | input | NCH | Value loaded into the mask vector |
| mask_o | output | NCH | Current mask vector |
| status_clr_i | input | 1 | Clear the status vector |
| status_o | output | NCH | Completion status vector |
| chan_base_i | input | NCH*CW | Per-channel base address, channel c at bits c*CW |
| chan_count_i | input | NCH*CW | Per-channel byte count minus one |
| cur_addr_o | output | NCH*CW | Per-channel current address |
| page_we_i | input | 1 | Page byte write strobe |
| page_chan_i | input | CH_W | Channel of the page write |
| page_off_i | input | 3 | Byte offset of the page write |
| page_wdata_i | input | 8 | Page write data |
| busy_o | output | 1 | A transfer is in progress |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench programs page bytes with nonzero upper bytes, a set direction flag and a write to an out-of-range offset. An engine that truncated the offset, reversed the byte order or let bit 7 or the upper bytes into the address would emit a wrong memory address. It runs a zero-count transfer next to a two-byte one with two channels requesting at once. An off-by-one count moves the wrong number of bytes, and an inverted priority writes the higher channel's addresses first. Verify and unused mode values must complete with no bus traffic. A wrong mode field slice would start a transfer. Bus wait states test that the engine holds its request and does not pass stale data to the destination, and a masked request must leave the engine idle.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRC,
        ST_DST,
        ST_DONE
    } xfer_state_t;

    typedef enum logic [1:0] {
        XK_VERIFY,
        XK_WRITE,
        XK_READ
    } xfer_kind_t;

    localparam int MODE_KIND_LSB = 2;
    localparam int MODE_KIND_W   = 4;
    localparam int PAGE_W        = 32;
    localparam int PAGE_BYTES    = PAGE_W / 8;

    // R4: kind field decode; unused codes fall back to verify
    function automatic xfer_kind_t kind_of(input logic [7:0] mode);
        logic [MODE_KIND_W-1:0] fld;
        fld = mode[MODE_KIND_LSB +: MODE_KIND_W];
        unique case (fld)
            4'd1:    kind_of = XK_WRITE;
            4'd2:    kind_of = XK_READ;
            default: kind_of = XK_VERIFY;
        endcase
    endfunction

endpackage

// File: rtl/dma_page_bank.sv
module dma_page_bank
    import dma_xfer_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CH_W  = 2,
    parameter int OFF_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CH_W-1:0]               chan,
    input  logic [OFF_W-1:0]              off,
    input  logic [7:0]                    wdata,
    output logic [NCH-1:0][PAGE_W-1:0]    page
);
    localparam int LANE_W = $clog2(PAGE_BYTES);

    logic              in_range;
    logic [LANE_W-1:0] lane;

    // R2: offsets beyond the last byte are dropped
    assign in_range = (off < OFF_W'(PAGE_BYTES));
    // R2: offset 0 addresses the most significant byte
    assign lane     = LANE_W'(PAGE_BYTES - 1) - off[LANE_W-1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_page
        logic [PAGE_W-1:0] pg_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pg_q <= '0;
            end else if (we && in_range && (chan == CH_W'(c))) begin
                pg_q[{lane, 3'b000} +: 8] <= wdata;
            end
        end

        assign page[c] = pg_q;
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  pend,
    output logic            valid,
    output logic [CH_W-1:0] idx
);
    // R8: scanning from the top down leaves the lowest pending index
    always_comb begin
        valid = |pend;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
    parameter int          AW         = 32,
    parameter int          CW         = 16,
    parameter int          PAGE_BITS  = 7,
    parameter int          PAGE_SHIFT = 16,
    parameter logic [31:0] MEM_BASE   = 32'h0200_0000
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] off,
    input  logic [31:0]   page,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] sum;
    logic [AW-1:0] field;

    // R3: base sum, then the low page bits OR'ed in above the window
    assign sum   = AW'(MEM_BASE) + AW'(base) + AW'(off);
    assign field = AW'(page[PAGE_BITS-1:0]) << PAGE_SHIFT;
    assign addr  = sum | field;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int                          NCH      = 4,
    parameter int                          AW       = 32,
    parameter int                          CW       = 16,
    parameter int                          CH_W     = $clog2(NCH),
    parameter logic [31:0]                 MEM_BASE = 32'h0200_0000,
    parameter logic [NCH-1:0][AW-1:0]      DEV_ADDR = {32'h0004_4010, 32'h0004_3010,
                                                       32'h0004_2010, 32'h0004_1010}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      drq_i,
    output logic [NCH-1:0]      handled_o,
    input  logic [7:0]          mode_i,
    input  logic                mask_ld_i,
    input  logic [NCH-1:0]      mask_val_i,
    output logic [NCH-1:0]      mask_o,
    input  logic                status_clr_i,
    output logic [NCH-1:0]      status_o,
    input  logic [NCH*CW-1:0]   chan_base_i,
    input  logic [NCH*CW-1:0]   chan_count_i,
    output logic [NCH*CW-1:0]   cur_addr_o,
    input  logic                page_we_i,
    input  logic [CH_W-1:0]     page_chan_i,
    input  logic [2:0]          page_off_i,
    input  logic [7:0]          page_wdata_i,
    output logic                busy_o,
    output logic                bus_req_o,
    output logic                bus_we_o,
    output logic [AW-1:0]       bus_addr_o,
    output logic [7:0]          bus_wdata_o,
    input  logic [7:0]          bus_rdata_i,
    input  logic                bus_ack_i
);
    localparam int PAGE_BITS  = 7;
    localparam int PAGE_SHIFT = 16;

    xfer_state_t state_q, state_d;
    xfer_kind_t  kind_q;

    logic [CH_W-1:0]            chan_q;
    logic [CW-1:0]              base_q;
    logic [CW-1:0]              count_q;
    logic [CW-1:0]              off_q;
    logic [7:0]                 data_q;
    logic [NCH-1:0]             mask_q;
    logic [NCH-1:0]             status_q;
    logic [NCH-1:0][CW-1:0]     cur_q;

    logic [NCH-1:0][PAGE_W-1:0] page_all;
    logic [NCH-1:0]             pend;
    logic                       pick_valid;
    logic [CH_W-1:0]            pick_idx;
    logic [AW-1:0]              mem_addr;
    logic [AW-1:0]              dev_addr;
    logic                       last_byte;
    logic                       mem_ack;
    logic [NCH-1:0]             done_vec;

    dma_page_bank #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .OFF_W (3)
    ) u_pages (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we_i),
        .chan  (page_chan_i),
        .off   (page_off_i),
        .wdata (page_wdata_i),
        .page  (page_all)
    );

    // R8: only requesting and unmasked channels compete
    assign pend = drq_i & ~mask_q;

    dma_prio_pick #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_pick (
        .pend  (pend),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    dma_addr_form #(
        .AW         (AW),
        .CW         (CW),
        .PAGE_BITS  (PAGE_BITS),
        .PAGE_SHIFT (PAGE_SHIFT),
        .MEM_BASE   (MEM_BASE)
    ) u_addr (
        .base (base_q),
        .off  (off_q),
        .page (page_all[chan_q]),
        .addr (mem_addr)
    );

    assign dev_addr  = DEV_ADDR[chan_q];
    assign last_byte = (off_q == count_q);

    // R7: the memory side is the source in read mode, the destination in write mode
    assign mem_ack = bus_ack_i &&
                     (((state_q == ST_SRC) && (kind_q == XK_READ)) ||
                      ((state_q == ST_DST) && (kind_q == XK_WRITE)));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_valid) begin
                    // R10: verify and unused codes go straight to completion
                    if (kind_of(mode_i) == XK_VERIFY) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_SRC;
                    end
                end
            end
            ST_SRC: begin
                if (bus_ack_i) begin
                    state_d = ST_DST;
                end
            end
            ST_DST: begin
                if (bus_ack_i) begin
                    // R5: stop after the byte at offset == count
                    state_d = last_byte ? ST_DONE : ST_SRC;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = data_q;
        done_vec    = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SRC: begin
                bus_req_o  = 1'b1;
                bus_we_o   = 1'b0;
                bus_addr_o = (kind_q == XK_WRITE) ? dev_addr : mem_addr;
            end
            ST_DST: begin
                bus_req_o  = 1'b1;
                bus_we_o   = 1'b1;
                bus_addr_o = (kind_q == XK_WRITE) ? mem_addr : dev_addr;
            end
            ST_DONE: begin
                done_vec = NCH'(1) << chan_q;
            end
            default: begin
            end
        endcase
    end

    assign handled_o  = done_vec;
    assign busy_o     = (state_q != ST_IDLE);
    assign mask_o     = mask_q;
    assign status_o   = status_q;
    assign cur_addr_o = cur_q;

    // ---------------- transfer datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            kind_q  <= XK_VERIFY;
            base_q  <= '0;
            count_q <= '0;
            off_q   <= '0;
            data_q  <= '0;
            cur_q   <= '0;
        end else begin
            if ((state_q == ST_IDLE) && pick_valid) begin
                // R4: channel setup and mode sampled once at grant
                chan_q  <= pick_idx;
                kind_q  <= kind_of(mode_i);
                base_q  <= chan_base_i[int'(pick_idx)*CW +: CW];
                count_q <= chan_count_i[int'(pick_idx)*CW +: CW];
                off_q   <= '0;
            end
            if ((state_q == ST_SRC) && bus_ack_i) begin
                data_q <= bus_rdata_i;
            end
            if ((state_q == ST_DST) && bus_ack_i && !last_byte) begin
                off_q <= off_q + CW'(1);
            end
            if (mem_ack) begin
                cur_q[chan_q] <= base_q + off_q;
            end
        end
    end

    // ---------------- mask and status ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '1;
            status_q <= '0;
        end else begin
            // R12: a host update never hides a completion in the same cycle
            mask_q   <= (mask_ld_i ? mask_val_i : mask_q) | done_vec;
            status_q <= (status_clr_i ? '0 : status_q) | done_vec;
        end
    end

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int NCH = 4,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] drq_i,
    input logic [NCH-1:0] handled_o,
    input logic [NCH-1:0] mask_o,
    input logic [NCH-1:0] status_o,
    input logic           busy_o,
    input logic           bus_req_o,
    input logic           bus_we_o,
    input logic [AW-1:0]  bus_addr_o,
    input logic [7:0]     bus_wdata_o,
    input logic           bus_ack_i
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                       $stable(bus_we_o) && $stable(bus_wdata_o))); // R6

    AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(drq_i & ~mask_o) != '0)); // R8

    AST_ONE_HANDLED: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(handled_o)); // R9

    AST_HANDLED_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (handled_o != '0) |=> (handled_o == '0)); // R9

    AST_DONE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (handled_o != '0) |=> ((mask_o & $past(handled_o)) == $past(handled_o))); // R9

    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (handled_o != '0) |=> ((status_o & $past(handled_o)) == $past(handled_o))); // R12

    AST_BUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> busy_o); // R11

    AST_HANDLED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (handled_o != '0) |-> busy_o); // R11

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
    .NCH (NCH),
    .AW  (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drq_i       (drq_i),
    .handled_o   (handled_o),
    .mask_o      (mask_o),
    .status_o    (status_o),
    .busy_o      (busy_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/dma_xfer_engine_test.sv
`timescale 1ns/1ps
module dma_xfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  drq = '0;
    logic [3:0]  handled;
    logic [7:0]  mode = '0;
    logic        mask_ld = 1'b0;
    logic [3:0]  mask_val = '0;
    logic [3:0]  mask;
    logic        status_clr = 1'b0;
    logic [3:0]  status;
    logic [63:0] bases = '0;
    logic [63:0] counts = '0;
    logic [63:0] cur;
    logic        page_we = 1'b0;
    logic [1:0]  page_chan = '0;
    logic [2:0]  page_off = '0;
    logic [7:0]  page_wdata = '0;
    logic        busy;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  rdata = '0;
    logic        ack = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [31:0] rd_addr [0:63];
    logic [31:0] wr_addr [0:63];
    logic [7:0]  wr_data [0:63];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [7:0]  dev_seq = 8'h10;
    int          lat = 0;
    int          wcnt = 0;
    int          hcnt [0:3] = '{0, 0, 0, 0};
    int          bad_pulse = 0;
    logic [3:0]  prev_handled = '0;

    localparam logic [31:0] MEMB = 32'h0200_0000;

    always #5 clk = ~clk;

    dma_xfer_engine uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .drq_i        (drq),
        .handled_o    (handled),
        .mode_i       (mode),
        .mask_ld_i    (mask_ld),
        .mask_val_i   (mask_val),
        .mask_o       (mask),
        .status_clr_i (status_clr),
        .status_o     (status),
        .chan_base_i  (bases),
        .chan_count_i (counts),
        .cur_addr_o   (cur),
        .page_we_i    (page_we),
        .page_chan_i  (page_chan),
        .page_off_i   (page_off),
        .page_wdata_i (page_wdata),
        .busy_o       (busy),
        .bus_req_o    (bus_req),
        .bus_we_o     (bus_we),
        .bus_addr_o   (bus_addr),
        .bus_wdata_o  (bus_wdata),
        .bus_rdata_i  (rdata),
        .bus_ack_i    (ack)
    );

    function automatic logic [31:0] dev_of(input int c);
        return 32'h0004_0010 + (32'(c + 1) << 12);
    endfunction

    function automatic logic [7:0] memf(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    // bus responder with programmable wait states
    always @(posedge clk) begin
        if (!rst_n) begin
            ack  <= 1'b0;
            wcnt <= 0;
        end else if (bus_req && !ack) begin
            if (wcnt >= lat) begin
                ack  <= 1'b1;
                wcnt <= 0;
                if (bus_we) begin
                    wr_addr[n_wr & 63] = bus_addr;
                    wr_data[n_wr & 63] = bus_wdata;
                    n_wr = n_wr + 1;
                end else begin
                    rd_addr[n_rd & 63] = bus_addr;
                    n_rd = n_rd + 1;
                    if (bus_addr < 32'h0100_0000) begin
                        rdata   <= dev_seq;
                        dev_seq = dev_seq + 8'd1;
                    end else begin
                        rdata <= memf(bus_addr);
                    end
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            ack <= 1'b0;
        end
    end

    // completion pulse monitor
    always @(posedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 4; c++) begin
                if (handled[c]) hcnt[c] = hcnt[c] + 1;
            end
            if ((handled & prev_handled) != '0) bad_pulse = bad_pulse + 1;
            if ((handled != '0) && !busy) bad_pulse = bad_pulse + 1;
            prev_handled = handled;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_mask(input logic [3:0] v);
        @(negedge clk);
        mask_ld  = 1'b1;
        mask_val = v;
        @(negedge clk);
        mask_ld  = 1'b0;
    endtask

    task automatic put_page(input int c, input int off, input logic [7:0] d);
        @(negedge clk);
        page_we    = 1'b1;
        page_chan  = 2'(c);
        page_off   = 3'(off);
        page_wdata = d;
        @(negedge clk);
        page_we    = 1'b0;
    endtask

    task automatic run_chan(input int c);
        int h0;
        h0 = hcnt[c];
        @(negedge clk);
        drq[c] = 1'b1;
        @(negedge clk);
        chk("R11 busy after grant", {31'd0, busy}, 32'd1);
        while (hcnt[c] == h0) @(negedge clk);
        drq[c] = 1'b0;
        @(negedge clk);
        chk("R9 one handled pulse", 32'(hcnt[c] - h0), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 mask", {28'd0, mask}, 32'hF);
        chk("R1 status", {28'd0, status}, 32'h0);
        chk("R1 busy/req", {30'd0, busy, bus_req}, 32'h0);
        chk("R1 handled", {28'd0, handled}, 32'h0);
        chk("R1 cur low", cur[31:0], 32'h0);
        chk("R1 cur high", cur[63:32], 32'h0);
    endtask

    task automatic t_write_ch1;
        int r0, w0;
        logic [7:0] s0;
        // R2: bytes by offset, out-of-range offsets must not land anywhere
        put_page(1, 0, 8'h11);
        put_page(1, 1, 8'h22);
        put_page(1, 2, 8'h33);
        put_page(1, 3, 8'h85);
        put_page(1, 7, 8'h0F);
        put_page(1, 4, 8'h7E);
        bases[31:16]  = 16'h1230;
        counts[31:16] = 16'd3;
        mode = 8'h85;                 // R4: field 1 = write, stray bits set
        lat  = 0;
        r0 = n_rd; w0 = n_wr; s0 = dev_seq;
        load_mask(4'b1101);
        run_chan(1);
        chk("R5 write byte reads", 32'(n_rd - r0), 32'd4);
        chk("R5 write byte writes", 32'(n_wr - w0), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R4 write src is device", rd_addr[(r0 + k) & 63], dev_of(1));
            chk("R3 R2 mem addr with page", wr_addr[(w0 + k) & 63], 32'h0205_1230 + 32'(k));
            chk("R6 data carried", {24'd0, wr_data[(w0 + k) & 63]}, {24'd0, s0 + 8'(k)});
        end
        chk("R7 cur after write", {16'd0, cur[31:16]}, 32'h1233);
        chk("R9 mask set", {28'd0, mask}, 32'hF);
        chk("R9 status set", {28'd0, status}, 32'h2);
    endtask

    task automatic t_read_ch2;
        int r0, w0;
        bases[47:32]  = 16'h0040;
        counts[47:32] = 16'd2;
        mode = 8'h08;                 // R4: field 2 = read
        lat  = 2;                     // R6: wait states
        r0 = n_rd; w0 = n_wr;
        load_mask(4'b1011);
        run_chan(2);
        lat = 0;
        chk("R5 read bytes", 32'(n_rd - r0), 32'd3);
        chk("R5 read writes", 32'(n_wr - w0), 32'd3);
        for (int k = 0; k < 3; k++) begin
            chk("R3 read mem addr", rd_addr[(r0 + k) & 63], MEMB + 32'h40 + 32'(k));
            chk("R4 read dst is device", wr_addr[(w0 + k) & 63], dev_of(2));
            chk("R6 read data carried", {24'd0, wr_data[(w0 + k) & 63]},
                {24'd0, memf(MEMB + 32'h40 + 32'(k))});
        end
        chk("R7 cur after read", {16'd0, cur[47:32]}, 32'h0042);
        chk("R9 status accumulates", {28'd0, status}, 32'h6);
    endtask

    task automatic t_status_clear;
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk("R12 status cleared", {28'd0, status}, 32'h0);
    endtask

    task automatic t_verify(input logic [7:0] m, input string tag);
        int r0, w0;
        bases[15:0]  = 16'h0100;
        counts[15:0] = 16'd5;
        mode = m;
        r0 = n_rd; w0 = n_wr;
        load_mask(4'b1110);
        run_chan(0);
        chk({"R10 no reads ", tag}, 32'(n_rd - r0), 32'd0);
        chk({"R10 no writes ", tag}, 32'(n_wr - w0), 32'd0);
        chk({"R7 cur unchanged ", tag}, {16'd0, cur[15:0]}, 32'h0);
        chk({"R9 mask ", tag}, {28'd0, mask}, 32'hF);
        chk({"R9 status ", tag}, {28'd0, status[0]}, 32'd1);
    endtask

    task automatic t_priority;
        int w0, h0, h3;
        logic [7:0] s0;
        put_page(3, 3, 8'h02);
        bases[15:0]   = 16'h0200;
        counts[15:0]  = 16'd1;
        bases[63:48]  = 16'h0300;
        counts[63:48] = 16'd0;        // R5: single byte
        mode = 8'h04;
        w0 = n_wr; s0 = dev_seq; h0 = hcnt[0]; h3 = hcnt[3];
        load_mask(4'b0110);
        @(negedge clk);
        drq = 4'b1001;
        while ((hcnt[0] == h0) || (hcnt[3] == h3)) @(negedge clk);
        drq = 4'b0000;
        @(negedge clk);
        chk("R8 total writes", 32'(n_wr - w0), 32'd3);
        chk("R8 low index first", wr_addr[w0 & 63], 32'h0200_0200);
        chk("R5 second byte", wr_addr[(w0 + 1) & 63], 32'h0200_0201);
        chk("R5 count zero one byte", wr_addr[(w0 + 2) & 63], 32'h0202_0300);
        chk("R6 ch3 data", {24'd0, wr_data[(w0 + 2) & 63]}, {24'd0, s0 + 8'd2});
        chk("R7 cur ch0", {16'd0, cur[15:0]}, 32'h0201);
        chk("R7 cur ch3", {16'd0, cur[63:48]}, 32'h0300);
        chk("R9 both masked", {28'd0, mask}, 32'hF);
    endtask

    task automatic t_masked;
        int r0, h2;
        r0 = n_rd; h2 = hcnt[2];
        @(negedge clk);
        drq[2] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) begin
                chk("R8 masked stays idle", {31'd0, busy}, 32'd0);
                break;
            end
        end
        drq[2] = 1'b0;
        chk("R8 masked no bus", 32'(n_rd - r0), 32'd0);
        chk("R8 masked no handled", 32'(hcnt[2] - h2), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ch1();
        t_read_ch2();
        t_status_clear();
        t_verify(8'h00, "verify");
        t_verify(8'h0C, "unused code");
        t_priority();
        t_masked();
        chk("R9 R11 pulse shape", 32'(bad_pulse), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule